// File: doc/BRIEF.md
# Ingress Frame Rate Limiter

This block polices traffic entering one switch port. For every frame that starts, it checks whether the frame belongs to a class being limited and charges the frame's byte cost to one of four per-priority budgets. It then tells the forwarding logic, one clock later, whether to keep the frame or discard it. Each budget is refilled at fixed intervals of `WIN_CYCLES` clocks, which is 1 ms at the intended clock rate. The allowance per interval is the selected bit rate divided by 8000, expressed in bytes.

Configuration arrives on static inputs. A 2-bit mode selects which frame classes are policed. Two enables add the fixed inter-frame gap (12 bytes) and preamble (8 bytes) overhead to each frame's cost. Each priority has a 4-bit rate code. On a 10 Mb/s link, any rate code above 10 Mb/s is treated as unlimited.

Top module: `ingress_rate_limiter`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first frame start, `decision_valid_o` and `drop_o` are 0.
- R2: `decision_valid_o` is 1 exactly in the clock after a clock where `frame_start_i` is 1, and 0 otherwise. `drop_o` is 1 only together with `decision_valid_o`.
- R3: Class codes are 00 known unicast, 01 flooded unicast, 10 multicast and 11 broadcast. Mode 00 polices every class. Mode 01 polices classes 01, 10 and 11. Mode 10 polices classes 10 and 11. Mode 11 polices class 11 only. A frame that is not policed is always accepted and charges nothing.
- R4: A policed frame costs its length in bytes, plus 12 when `add_ifg_i` is 1, plus 8 when `add_pre_i` is 1.
- R5: The per-window byte allowance for rate codes 1 to 15 is, in order: 8, 16, 32, 64, 125, 250, 500, 1000, 2000, 4000, 6000, 8000, 9000, 10000 and 11000.
- R6: A policed frame is dropped when its priority's counter, taken before this frame, is greater than or equal to the allowance. An accepted frame adds its full cost, even if this takes the counter past the allowance. A dropped frame adds nothing.
- R7: Rate code 0 means unlimited: frames of that priority are never dropped.
- R8: When `link_10m_i` is 1, rate codes 9 to 15 behave as code 0. Codes 1 to 8 keep their allowance.
- R9: The four priorities have independent counters. The rate code for priority p is `rate_code_i[4p+3:4p]`.
- R10: All counters return to zero on every clock k, counted from 0 at the first clock after reset release, where (k+1) is a multiple of `WIN_CYCLES`. A frame that starts on that clock is judged against a zero counter and charged to the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | One-cycle strobe marking the start of a frame |
| frame_len_i | input | LEN_W | Frame length in bytes, qualified by the strobe |
| frame_class_i | input | 2 | Frame class code, qualified by the strobe |
| frame_prio_i | input | 2 | Frame priority, qualified by the strobe |
| link_10m_i | input | 1 | 1 for a 10 Mb/s link, 0 for 100 Mb/s |
| limit_mode_i | input | 2 | Selects which classes are policed |
| add_ifg_i | input | 1 | Adds 12 bytes of gap overhead to each cost |
| add_pre_i | input | 1 | Adds 8 bytes of preamble overhead to each cost |
| rate_code_i | input | 16 | Four 4-bit rate codes, priority 0 in the low nibble |
| decision_valid_o | output | 1 | High one clock after each frame start |
| drop_o | output | 1 | 1 means discard the frame, valid with `decision_valid_o` |

## Verification
The counter assertions assume that the frame length plus 20 bytes fits the cost width. They also assume that the class, priority and length inputs matter only in a strobe cycle. The stimulus keeps lengths at or below 2000 bytes. It changes the mode, enables, link flag and rate codes only in cycles without a strobe. After each change, it realigns to the start of a window, so that every expected decision follows from counters that have been cleared.

// File: rtl/irl_pkg.sv
package irl_pkg;

  typedef enum logic [1:0] {
    CLS_KNOWN_UC = 2'b00,
    CLS_FLOOD_UC = 2'b01,
    CLS_MCAST    = 2'b10,
    CLS_BCAST    = 2'b11
  } frame_class_e;

  typedef enum logic [1:0] {
    MODE_ALL   = 2'b00,
    MODE_FLOOD = 2'b01,
    MODE_MCAST = 2'b10,
    MODE_BCAST = 2'b11
  } limit_mode_e;

  localparam int unsigned GAP_BYTES      = 12;
  localparam int unsigned PREAMBLE_BYTES = 8;
  localparam int unsigned OVERHEAD_MAX   = GAP_BYTES + PREAMBLE_BYTES;
  localparam logic [3:0]  SLOW_CLAMP_MIN = 4'd9;
  localparam int unsigned RATE_CODE_W    = 4;

  // Bytes allowed per 1 ms window for each rate code (bit rate / 8000).
  function automatic logic [15:0] window_bytes(input logic [3:0] code);
    logic [15:0] b;
    unique case (code)
      4'd1:    b = 16'd8;
      4'd2:    b = 16'd16;
      4'd3:    b = 16'd32;
      4'd4:    b = 16'd64;
      4'd5:    b = 16'd125;
      4'd6:    b = 16'd250;
      4'd7:    b = 16'd500;
      4'd8:    b = 16'd1000;
      4'd9:    b = 16'd2000;
      4'd10:   b = 16'd4000;
      4'd11:   b = 16'd6000;
      4'd12:   b = 16'd8000;
      4'd13:   b = 16'd9000;
      4'd14:   b = 16'd10000;
      4'd15:   b = 16'd11000;
      default: b = 16'd0;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/irl_window_timer.sv
module irl_window_timer #(
  parameter int unsigned WIN_CYCLES = 125000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned WCW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WCW-1:0] LAST = WCW'(WIN_CYCLES - 1);

  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic           wrap;

  always_comb begin
    wrap   = (wcnt_q == LAST);
    wcnt_d = wrap ? '0 : wcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt_q <= '0;
    else        wcnt_q <= wcnt_d;
  end

  assign tick_o = wrap;

  // R10
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= LAST);

  // R10
  win_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (wcnt_q == '0));

endmodule

// File: rtl/irl_frame_filter.sv
module irl_frame_filter
  import irl_pkg::*;
#(
  parameter int unsigned LEN_W  = 11,
  parameter int unsigned COST_W = LEN_W + 1
) (
  input  logic [1:0]        frame_class_i,
  input  logic [1:0]        limit_mode_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic              add_ifg_i,
  input  logic              add_pre_i,
  output logic              counted_o,
  output logic [COST_W-1:0] cost_o
);
  frame_class_e cls;
  limit_mode_e  mode;
  logic [COST_W-1:0] gap_part, pre_part;

  always_comb begin
    cls  = frame_class_e'(frame_class_i);
    mode = limit_mode_e'(limit_mode_i);
    unique case (mode)
      MODE_ALL:   counted_o = 1'b1;
      MODE_FLOOD: counted_o = (cls != CLS_KNOWN_UC);
      MODE_MCAST: counted_o = (cls == CLS_MCAST) || (cls == CLS_BCAST);
      MODE_BCAST: counted_o = (cls == CLS_BCAST);
      default:    counted_o = 1'b1;
    endcase
  end

  always_comb begin
    gap_part = add_ifg_i ? COST_W'(GAP_BYTES)      : '0;
    pre_part = add_pre_i ? COST_W'(PREAMBLE_BYTES) : '0;
    cost_o   = COST_W'(frame_len_i) + gap_part + pre_part;
  end

endmodule

// File: rtl/irl_prio_budget.sv
module irl_prio_budget
  import irl_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned COST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_tick_i,
  input  logic [3:0]        rate_code_i,
  input  logic              link_10m_i,
  input  logic              charge_i,
  input  logic [COST_W-1:0] cost_i,
  output logic              limited_o,
  output logic              exhausted_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] allow;
  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] sum_sat;

  // Allowance decode and the slow-link clamp.
  always_comb begin
    allow     = CNT_W'(window_bytes(rate_code_i));
    limited_o = (rate_code_i != 4'd0) &&
                !(link_10m_i && (rate_code_i >= SLOW_CLAMP_MIN));
  end

  // A window boundary makes the counter read as zero for this cycle.
  always_comb begin
    base        = win_tick_i ? '0 : cnt_q;
    exhausted_o = limited_o && (base >= allow);
    sum         = {1'b0, base} + (CNT_W+1)'(cost_i);
    sum_sat     = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end

  always_comb begin
    if (charge_i)        cnt_d = sum_sat;
    else if (win_tick_i) cnt_d = '0;
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6
  charge_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    charge_i |=> (cnt_q >= {{(CNT_W-COST_W){1'b0}}, $past(cost_i)}));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!charge_i && !win_tick_i) |=> $stable(cnt_q));

  // R10
  win_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_tick_i && !charge_i) |=> (cnt_q == '0));

endmodule

// File: rtl/ingress_rate_limiter.sv
module ingress_rate_limiter
  import irl_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 125000,
  parameter int unsigned LEN_W      = 11,
  parameter int unsigned N_PRIO     = 4,
  parameter int unsigned CNT_W      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_start_i,
  input  logic [LEN_W-1:0]              frame_len_i,
  input  logic [1:0]                    frame_class_i,
  input  logic [$clog2(N_PRIO)-1:0]     frame_prio_i,
  input  logic                          link_10m_i,
  input  logic [1:0]                    limit_mode_i,
  input  logic                          add_ifg_i,
  input  logic                          add_pre_i,
  input  logic [N_PRIO*RATE_CODE_W-1:0] rate_code_i,
  output logic                          decision_valid_o,
  output logic                          drop_o
);
  localparam int unsigned PRIO_W = $clog2(N_PRIO);
  localparam int unsigned COST_W = LEN_W + 1;

  logic              win_tick;
  logic              counted;
  logic [COST_W-1:0] cost;
  logic [N_PRIO-1:0] limited_vec, exhausted_vec, charge_vec;
  logic              sel_exhausted;
  logic              valid_q, valid_d, drop_q, drop_d;

  irl_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (win_tick)
  );

  irl_frame_filter #(.LEN_W(LEN_W), .COST_W(COST_W)) u_filter (
    .frame_class_i (frame_class_i),
    .limit_mode_i  (limit_mode_i),
    .frame_len_i   (frame_len_i),
    .add_ifg_i     (add_ifg_i),
    .add_pre_i     (add_pre_i),
    .counted_o     (counted),
    .cost_o        (cost)
  );

  assign sel_exhausted = exhausted_vec[frame_prio_i];

  for (genvar p = 0; p < N_PRIO; p++) begin : g_prio
    assign charge_vec[p] = frame_start_i && counted && !sel_exhausted &&
                           (frame_prio_i == PRIO_W'(p));

    irl_prio_budget #(.CNT_W(CNT_W), .COST_W(COST_W)) u_budget (
      .clk         (clk),
      .rst_n       (rst_n),
      .win_tick_i  (win_tick),
      .rate_code_i (rate_code_i[p*RATE_CODE_W +: RATE_CODE_W]),
      .link_10m_i  (link_10m_i),
      .charge_i    (charge_vec[p]),
      .cost_i      (cost),
      .limited_o   (limited_vec[p]),
      .exhausted_o (exhausted_vec[p])
    );
  end

  always_comb begin
    valid_d = frame_start_i;
    drop_d  = frame_start_i && counted && sel_exhausted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      drop_q  <= drop_d;
    end
  end

  assign decision_valid_o = valid_q;
  assign drop_o           = drop_q;

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_i |=> !decision_valid_o);

  // R2
  drop_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> decision_valid_o);

  // R7
  unlimited_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && !limited_vec[frame_prio_i]) |=> !drop_o);

  // R3
  uncounted_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && !counted) |=> !drop_o);

  // R9
  single_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(charge_vec));

endmodule

// File: tb/sim_ingress_rate_limiter.sv
module sim_ingress_rate_limiter;
  localparam int W = 300;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_start_i;
  logic [10:0] frame_len_i;
  logic [1:0]  frame_class_i;
  logic [1:0]  frame_prio_i;
  logic        link_10m_i;
  logic [1:0]  limit_mode_i;
  logic        add_ifg_i;
  logic        add_pre_i;
  logic [15:0] rate_code_i;
  logic        decision_valid_o;
  logic        drop_o;

  int errors = 0;
  int checks = 0;
  int kcnt   = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) kcnt <= kcnt + 1;

  ingress_rate_limiter #(.WIN_CYCLES(W)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
    .frame_len_i(frame_len_i), .frame_class_i(frame_class_i),
    .frame_prio_i(frame_prio_i), .link_10m_i(link_10m_i),
    .limit_mode_i(limit_mode_i), .add_ifg_i(add_ifg_i),
    .add_pre_i(add_pre_i), .rate_code_i(rate_code_i),
    .decision_valid_o(decision_valid_o), .drop_o(drop_o)
  );

  // {class[15:14], prio[13:12], len[11:1], drop[0]}; mode 00, gap on, codes p3=15 p2=5 p1=0 p0=1
  localparam logic [15:0] VEC [10] = '{
    {2'd0, 2'd0, 11'd64,   1'b0},
    {2'd0, 2'd0, 11'd64,   1'b1},
    {2'd1, 2'd1, 11'd1500, 1'b0},
    {2'd2, 2'd2, 11'd100,  1'b0},
    {2'd3, 2'd2, 11'd60,   1'b0},
    {2'd0, 2'd2, 11'd60,   1'b1},
    {2'd1, 2'd3, 11'd1500, 1'b0},
    {2'd3, 2'd0, 11'd64,   1'b1},
    {2'd2, 2'd3, 11'd2000, 1'b0},
    {2'd3, 2'd1, 11'd2000, 1'b0}
  };

  function automatic int allow_of(input int code);
    case (code)
      1: return 8;       2: return 16;      3: return 32;
      4: return 64;      5: return 125;     6: return 250;
      7: return 500;     8: return 1000;    9: return 2000;
      10: return 4000;   11: return 6000;   12: return 8000;
      13: return 9000;   14: return 10000;  15: return 11000;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; the decision is sampled at the next falling edge.
  task automatic send(input logic [1:0] cls, input logic [1:0] pri,
                      input int len, input bit exp_drop, input string req);
    frame_start_i = 1'b1;
    frame_class_i = cls;
    frame_prio_i  = pri;
    frame_len_i   = 11'(len);
    @(negedge clk);
    frame_start_i = 1'b0;
    check(decision_valid_o === 1'b1, {req, " valid"}, int'(decision_valid_o), 1);
    check(drop_o === exp_drop, req, int'(drop_o), int'(exp_drop));
  endtask

  // Wait until the next rising edge is the first clock of a window.
  task automatic align();
    @(negedge clk);
    while (((kcnt + 1) % W) != 0) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] mode, input bit ifg, input bit pre,
                         input bit slow, input logic [15:0] codes);
    limit_mode_i = mode; add_ifg_i = ifg; add_pre_i = pre;
    link_10m_i = slow; rate_code_i = codes;
  endtask

  // R5 probe: allowance-1 bytes pass, one more byte passes, the next is dropped.
  task automatic probe(input int code, input bit slow, input int allow, input string req);
    int rem;
    set_cfg(2'd0, 1'b0, 1'b0, slow, {12'h000, 4'(code)});
    align();
    rem = allow - 1;
    while (rem > 0) begin
      int l;
      l = (rem > 2000) ? 2000 : rem;
      send(2'd3, 2'd0, l, 1'b0, req);
      rem -= l;
    end
    send(2'd3, 2'd0, 1, 1'b0, req);
    send(2'd3, 2'd0, 1, 1'b1, req);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    frame_start_i = 1'b0; frame_len_i = '0; frame_class_i = '0; frame_prio_i = '0;
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 16'h0000);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(decision_valid_o === 1'b0, "R1 valid in reset", int'(decision_valid_o), 0);
    check(drop_o === 1'b0, "R1 drop in reset", int'(drop_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(decision_valid_o === 1'b0, "R1 valid after reset", int'(decision_valid_o), 0);
    check(drop_o === 1'b0, "R1 drop after reset", int'(drop_o), 0);

    // R6 R4 table walk
    set_cfg(2'd0, 1'b1, 1'b0, 1'b0, 16'hF501);
    align();
    for (int i = 0; i < 10; i++) begin
      send(VEC[i][15:14], VEC[i][13:12], int'(VEC[i][11:1]), VEC[i][0], "R6 table");
      @(negedge clk);
      // R2 no decision without a strobe
      check(decision_valid_o === 1'b0, "R2 idle", int'(decision_valid_o), 0);
    end

    // R3 broadcast-only mode
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 16'h0001);
    align();
    send(2'd2, 2'd0, 64, 1'b0, "R3 mode11 mcast ignored");
    send(2'd3, 2'd0, 4, 1'b0, "R3 mode11 bcast");
    send(2'd3, 2'd0, 4, 1'b0, "R3 mode11 bcast");
    send(2'd3, 2'd0, 1, 1'b1, "R3 mode11 bcast over");
    send(2'd2, 2'd0, 1, 1'b0, "R3 mode11 mcast pass");
    send(2'd1, 2'd0, 1, 1'b0, "R3 mode11 flood pass");
    send(2'd0, 2'd0, 1, 1'b0, "R3 mode11 known pass");
    // R3 mode 01
    set_cfg(2'd1, 1'b0, 1'b0, 1'b0, 16'h0001);
    align();
    send(2'd0, 2'd0, 100, 1'b0, "R3 mode01 known ignored");
    send(2'd1, 2'd0, 8, 1'b0, "R3 mode01 flood");
    send(2'd1, 2'd0, 1, 1'b1, "R3 mode01 flood over");
    send(2'd0, 2'd0, 1, 1'b0, "R3 mode01 known pass");
    // R3 mode 10
    set_cfg(2'd2, 1'b0, 1'b0, 1'b0, 16'h0001);
    align();
    send(2'd1, 2'd0, 100, 1'b0, "R3 mode10 flood ignored");
    send(2'd2, 2'd0, 8, 1'b0, "R3 mode10 mcast");
    send(2'd3, 2'd0, 1, 1'b1, "R3 mode10 bcast over");
    send(2'd1, 2'd0, 1, 1'b0, "R3 mode10 flood pass");

    // R4 overhead, priority 2 at 125 bytes
    set_cfg(2'd0, 1'b0, 1'b1, 1'b0, 16'h0500);
    align(); send(2'd0, 2'd2, 117, 1'b0, "R4 pre"); send(2'd0, 2'd2, 1, 1'b1, "R4 pre over");
    align(); send(2'd0, 2'd2, 116, 1'b0, "R4 pre"); send(2'd0, 2'd2, 1, 1'b0, "R4 pre under");
    set_cfg(2'd0, 1'b1, 1'b0, 1'b0, 16'h0500);
    align(); send(2'd0, 2'd2, 113, 1'b0, "R4 gap"); send(2'd0, 2'd2, 1, 1'b1, "R4 gap over");
    align(); send(2'd0, 2'd2, 112, 1'b0, "R4 gap"); send(2'd0, 2'd2, 1, 1'b0, "R4 gap under");
    set_cfg(2'd0, 1'b1, 1'b1, 1'b0, 16'h0500);
    align(); send(2'd0, 2'd2, 105, 1'b0, "R4 both"); send(2'd0, 2'd2, 1, 1'b1, "R4 both over");
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 16'h0500);
    align(); send(2'd0, 2'd2, 124, 1'b0, "R4 none"); send(2'd0, 2'd2, 1, 1'b0, "R4 none under");

    // R5 allowance table on a fast link
    for (int c = 1; c < 16; c++) probe(c, 1'b0, allow_of(c), "R5 rate table");

    // R7 unlimited code
    set_cfg(2'd0, 1'b1, 1'b1, 1'b0, 16'h0000);
    align();
    for (int i = 0; i < 6; i++) send(2'd3, 2'd0, 2000, 1'b0, "R7 code0");

    // R8 slow link clamp
    probe(8, 1'b1, 1000, "R8 slow code8 kept");
    for (int c = 9; c < 16; c += 6) begin
      set_cfg(2'd0, 1'b0, 1'b0, 1'b1, {12'h000, 4'(c)});
      align();
      for (int i = 0; i < 7; i++) send(2'd3, 2'd0, 2000, 1'b0, "R8 slow clamp");
    end

    // R9 independent priorities and field placement
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 16'h0051);
    align();
    send(2'd0, 2'd0, 8, 1'b0, "R9 p0");
    send(2'd0, 2'd0, 1, 1'b1, "R9 p0 over");
    send(2'd0, 2'd1, 100, 1'b0, "R9 p1 own budget");
    send(2'd0, 2'd1, 25, 1'b0, "R9 p1");
    send(2'd0, 2'd1, 1, 1'b1, "R9 p1 over");
    send(2'd0, 2'd0, 1, 1'b1, "R9 p0 still over");
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 16'h1000);
    align();
    send(2'd0, 2'd3, 8, 1'b0, "R9 p3 field");
    send(2'd0, 2'd3, 1, 1'b1, "R9 p3 over");
    send(2'd0, 2'd0, 2000, 1'b0, "R9 p0 unlimited");
    send(2'd0, 2'd0, 2000, 1'b0, "R9 p0 unlimited");

    // R6 overshoot by one accepted frame
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 16'h0500);
    align();
    send(2'd0, 2'd2, 124, 1'b0, "R6 under");
    send(2'd0, 2'd2, 2000, 1'b0, "R6 overshoot accepted");
    send(2'd0, 2'd2, 1, 1'b1, "R6 after overshoot");

    // R10 window boundary, frames back to back across it
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 16'h0001);
    align();
    send(2'd0, 2'd0, 8, 1'b0, "R10 first");
    @(negedge clk);
    while (((kcnt + 2) % W) != 0) @(negedge clk);
    send(2'd0, 2'd0, 1, 1'b1, "R10 last clock of window");
    send(2'd0, 2'd0, 8, 1'b0, "R10 boundary clock fresh");
    send(2'd0, 2'd0, 1, 1'b1, "R10 charged to new window");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule